// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked static memory of 9-bit words, meant as the data store of a cache. All of its inputs are sampled on the rising clock edge, except the output enable. These sampled inputs are the address, the write data, the write strobe, the two chip selects and the burst controls.

A burst is opened by one of two address strobes. The host processor drives the first strobe and the cache controller drives the second. Either strobe loads the address from the pins. After that, an internal 2-bit counter produces the next three word addresses of the aligned 4-word block. The counter steps only on cycles where the advance input is asserted. On the other continuation cycles it holds, and the access at the current address is repeated.

A read places registered data on the output one clock after the address is taken. A write lands in the array at the edge that samples it, so no separate write pulse is needed. The shared data bus is split into separate input data, output data and output-drive-enable ports.

Top module: `bsram_top`

## Requirements
- R1: The array holds 2**ADDR_W words of 9 bits each. ADDR_W=15 gives 32,768 words. A word written at any address, including address 0 and the highest address, reads back unchanged.
- R2: A read taken at clock edge N shows its word on `dout` after edge N. In that same cycle `dout_en` is high while `oe_n` is low.
- R3: `dout_en` follows `oe_n` with no clock edge involved. `oe_n` high forces `dout_en` low at once, and `oe_n` low drives the held read data again at once.
- R4: The block is selected only when `cs_hi`=1 and `cs_lo_n`=0. A strobe while not selected closes any open burst, makes no access and writes nothing. `dout_en` is low in the next cycle.
- R5: A selected strobe on either `ads_proc_n` or `ads_ctrl_n` (both active low) loads `addr` as the burst base and clears the burst count to 0. That cycle accesses `addr` itself.
- R6: Burst addresses are interleaved. Bits [1:0] equal the base bits [1:0] XOR the count. A base ending in 0 gives 0,1,2,3, and a base ending in 1 gives 1,0,3,2.
- R7: On a continuation cycle (burst open, no strobe), the count advances by one only when `adv_n`=0. With `adv_n`=1 the count holds and the same address is accessed again. Chip selects are not looked at on continuation cycles.
- R8: The count wraps after four accesses and stays inside the aligned 4-word block. Address bits above bit 1 never change during a burst.
- R9: When both strobes are asserted on the same selected edge, the processor strobe wins. A processor-strobe cycle is always a read, even when `we_n`=0.
- R10: Cycles opened by the controller strobe, and continuation cycles, write `din` at the sampling edge when `we_n`=0. This is true at every interleaved address of a burst.
- R11: After reset no burst is open and `dout_en` is low.
- R12: With no burst open and no strobe asserted, a cycle makes no access, whatever `adv_n` and `we_n` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs except `oe_n` are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Word address, taken on strobe cycles |
| din | input | DATA_W | Write data |
| we_n | input | 1 | Write strobe, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Cache-controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DATA_W | Read data register |
| dout_en | output | 1 | Drive enable for the shared data bus |

## Verification
The bench opens bursts at all four low-address offsets and runs each one through eight beats. A design with linear instead of interleaved order would fail the base-1 and base-3 bursts. A design that carried into bit 2 would fail the wrap beats. Stalls with `adv_n` high are checked so that a counter that steps freely shows up. Strobes with only one chip select asserted must leave memory and output untouched, which catches a select decoded with OR or one that ignores a pin. Two further cases are checked: both strobes with `we_n` low must read rather than write, and a continuation with no open burst must do nothing. These expose a wrong strobe priority and a counter that starts without a strobe.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  // Interleaved burst order: the low two address bits are the base bits XOR the count.
  function automatic logic [1:0] burst_lane(input logic [1:0] base_lo, input logic [1:0] cnt);
    return base_lo ^ cnt;
  endfunction

  // Next count: steps by one and wraps modulo 4.
  function automatic logic [1:0] burst_next(input logic [1:0] cnt);
    return cnt + 2'd1;
  endfunction
endpackage

// File: rtl/bsram_decode.sv
module bsram_decode (
  input  logic cs_hi,
  input  logic cs_lo_n,
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic adv_n,
  input  logic we_n,
  input  logic burst_open,
  output logic sel,
  output logic load,
  output logic drop,
  output logic cont,
  output logic step,
  output logic proc_cyc,
  output logic rd_en,
  output logic wr_en
);
  logic any_strobe;
  logic access;

  always_comb begin
    sel        = cs_hi & ~cs_lo_n;
    any_strobe = ~ads_proc_n | ~ads_ctrl_n;
    load       = any_strobe & sel;
    drop       = any_strobe & ~sel;
    cont       = ~any_strobe & burst_open;
    step       = cont & ~adv_n;
    proc_cyc   = ~ads_proc_n & sel;
    access     = load | cont;
    wr_en      = access & ~proc_cyc & ~we_n;
    rd_en      = access & ~wr_en;
  end
endmodule

// File: rtl/bsram_burst_ctrl.sv
module bsram_burst_ctrl #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load,
  input  logic              drop,
  input  logic              cont,
  input  logic              step,
  output logic              burst_open,
  output logic [ADDR_W-1:0] eff_addr
);
  import bsram_pkg::*;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              open_q;

  always_comb begin
    base_d = load ? addr : base_q;
    if (load)      cnt_d = 2'd0;
    else if (step) cnt_d = burst_next(cnt_q);
    else           cnt_d = cnt_q;
    eff_addr = {base_d[ADDR_W-1:2], burst_lane(base_d[1:0], cnt_d)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= 2'd0;
      open_q <= 1'b0;
    end else begin
      base_q <= base_d;
      cnt_q  <= cnt_d;
      if (load)      open_q <= 1'b1;
      else if (drop) open_q <= 1'b0;
    end
  end

  assign burst_open = open_q;

  p_cnt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == 2'd0));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt_q == $past(cnt_q) + 2'd1));
  p_cnt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && !step) |=> $stable(cnt_q));
  p_block_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cont |=> $stable(base_q[ADDR_W-1:2]));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [DATA_W-1:0] din,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[eff_addr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mem[eff_addr];
    end
  end

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
endmodule

// File: rtl/bsram_top.sv
module bsram_top #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              we_n,
  input  logic              cs_hi,
  input  logic              cs_lo_n,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              adv_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic              sel, load, drop, cont, step, proc_cyc, rd_en, wr_en;
  logic              burst_open, rd_valid;
  logic [ADDR_W-1:0] eff_addr;

  bsram_decode u_dec (
    .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n),
    .adv_n(adv_n), .we_n(we_n), .burst_open(burst_open), .sel(sel), .load(load),
    .drop(drop), .cont(cont), .step(step), .proc_cyc(proc_cyc), .rd_en(rd_en), .wr_en(wr_en)
  );

  bsram_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .load(load), .drop(drop), .cont(cont),
    .step(step), .burst_open(burst_open), .eff_addr(eff_addr)
  );

  bsram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .eff_addr(eff_addr), .din(din), .rd_en(rd_en),
    .wr_en(wr_en), .rd_data(dout), .rd_valid(rd_valid)
  );

  assign dout_en = rd_valid & ~oe_n;

  p_proc_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proc_cyc |=> rd_valid);
  p_desel_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !rd_valid);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst_open && ads_proc_n && ads_ctrl_n) |=> !rd_valid);
endmodule

// File: tb/tb_bsram_top.sv
`timescale 1ns/100ps
module tb_bsram_top;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic we_n = 1'b1, cs_hi = 1'b0, cs_lo_n = 1'b1;
  logic ads_proc_n = 1'b1, ads_ctrl_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
  logic [DW-1:0] dout;
  logic dout_en;

  logic [DW-1:0] refm [DEPTH];
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bsram_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .we_n(we_n), .cs_hi(cs_hi),
    .cs_lo_n(cs_lo_n), .ads_proc_n(ads_proc_n), .ads_ctrl_n(ads_ctrl_n), .adv_n(adv_n),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle, pass the rising edge, and settle 1 ns after it.
  // cs = {cs_hi, cs_lo_n}; 2'b10 selects the block.
  task automatic cyc(input logic ap, input logic ac, input logic av, input logic we,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] cs);
    ads_proc_n = ap; ads_ctrl_n = ac; adv_n = av; we_n = we;
    addr = a; din = d; cs_hi = cs[1]; cs_lo_n = cs[0];
    @(posedge clk); #1;
  endtask

  function automatic logic [AW-1:0] ilv(input logic [AW-1:0] b, input int k);
    logic [1:0] kk;
    kk = k[1:0];
    return {b[AW-1:2], b[1:0] ^ kk};
  endfunction

  task automatic t_reset();
    chk("R11 dout_en in reset", {8'd0, dout_en}, 9'd0);
    rst_n = 1'b1;
    cyc(1, 1, 0, 1, '0, '0, 2'b10);
    chk("R11 no burst open after reset", {8'd0, dout_en}, 9'd0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < DEPTH; i++) begin
      refm[i] = DW'((i * 37 + 5) & 9'h1FF);
      cyc(1, 0, 1, 0, AW'(i), refm[i], 2'b10);
    end
    cyc(1, 1, 1, 1, '0, '0, 2'b00);
    cyc(0, 1, 1, 1, AW'(DEPTH - 1), '0, 2'b10);
    chk("R1 top address", dout, refm[DEPTH-1]);
    cyc(0, 1, 1, 1, '0, '0, 2'b10);
    chk("R1 address zero", dout, refm[0]);
    chk("R2 drive enable on read", {8'd0, dout_en}, 9'd1);
  endtask

  task automatic t_burst(input logic [AW-1:0] b);
    cyc(0, 1, 1, 1, b, '0, 2'b10);
    chk("R5 strobe loads address", dout, refm[b]);
    for (int k = 1; k < 8; k++) begin
      cyc(1, 1, 0, 1, '0, '0, 2'b00);
      if (k < 4) chk("R6 interleaved beat", dout, refm[ilv(b, k)]);
      else       chk("R8 wrap in block", dout, refm[ilv(b, k)]);
    end
  endtask

  task automatic t_stall(input logic [AW-1:0] b);
    cyc(1, 0, 1, 1, b, '0, 2'b10);
    cyc(1, 1, 0, 1, '0, '0, 2'b10);
    cyc(1, 1, 1, 1, '0, '0, 2'b10);
    chk("R7 stall repeats address", dout, refm[ilv(b, 1)]);
    cyc(1, 1, 1, 1, '0, '0, 2'b01);
    chk("R7 second stall", dout, refm[ilv(b, 1)]);
    cyc(1, 1, 0, 1, '0, '0, 2'b10);
    chk("R7 advance after stall", dout, refm[ilv(b, 2)]);
  endtask

  task automatic t_burst_write(input logic [AW-1:0] b);
    for (int k = 0; k < 4; k++) begin
      logic [DW-1:0] v;
      v = DW'(9'h100 + k * 9'h11 + b);
      if (k == 0) cyc(1, 0, 1, 0, b, v, 2'b10);
      else        cyc(1, 1, 0, 0, '0, v, 2'b00);
      refm[ilv(b, k)] = v;
    end
    chk("R10 no drive during writes", {8'd0, dout_en}, 9'd0);
    t_burst(b);
  endtask

  task automatic t_desel(input logic [AW-1:0] a, input logic [1:0] cs);
    cyc(1, 0, 1, 0, a, ~refm[a], cs);
    chk("R4 deselected strobe no output", {8'd0, dout_en}, 9'd0);
    cyc(1, 1, 0, 0, '0, 9'h0AA, 2'b10);
    chk("R12 idle cycle no access", {8'd0, dout_en}, 9'd0);
    cyc(0, 1, 1, 1, a, '0, 2'b10);
    chk("R4 deselected write ignored", dout, refm[a]);
    cyc(1, 1, 0, 1, '0, '0, 2'b10);
    chk("R12 idle write ignored", dout, refm[ilv(a, 1)]);
  endtask

  task automatic t_both(input logic [AW-1:0] a);
    cyc(0, 0, 1, 0, a, ~refm[a], 2'b10);
    chk("R9 both strobes read", dout, refm[a]);
    chk("R9 read drives bus", {8'd0, dout_en}, 9'd1);
    cyc(0, 1, 1, 1, a, '0, 2'b10);
    chk("R9 processor strobe did not write", dout, refm[a]);
  endtask

  task automatic t_oe(input logic [AW-1:0] a);
    cyc(0, 1, 1, 1, a, '0, 2'b10);
    oe_n = 1'b1; #1;
    chk("R3 oe_n high releases bus", {8'd0, dout_en}, 9'd0);
    oe_n = 1'b0; #1;
    chk("R3 oe_n low drives again", {8'd0, dout_en}, 9'd1);
    chk("R3 held data", dout, refm[a]);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #12;
    t_reset();
    t_fill();
    t_burst(10'h040);
    t_burst(10'h041);
    t_burst(10'h0A2);
    t_burst(10'h3FF);
    t_stall(10'h125);
    t_burst_write(10'h203);
    t_burst_write(10'h1FD);
    t_desel(10'h050, 2'b11);
    t_desel(10'h061, 2'b00);
    t_both(10'h077);
    t_oe(10'h088);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule